// File: doc/BRIEF.md
# Clamped PI Current Regulator

This block closes the inner current loop of a bridge-driven thermoelectric element. On every sample strobe it forms the signed error between a commanded current and a measured current. It advances a first-order proportional-integral recursion with programmable fixed-point coefficients and bounds the result between programmable limits. The bounded value is the only history kept, so the integrator cannot wind up past the limits.

The bounded controller output is mapped linearly onto a high-side on-time count between a programmable minimum and maximum. It also selects which half of the bridge switches: a positive output drives side A, which pushes current from side A to side B. A negative output drives side B. An output inside a programmable deadband around zero idles both sides. A slower outer temperature loop supplies the target. A PWM generator downstream consumes the on-time and mode.

Top module: `tec_pi_reg`

## Requirements
- R1: The error used on a strobe is `target - meas`, taken as signed values. With `coef_a1 = 0`, `coef_b1 = 0` and `coef_b0 = 2^FRAC`, the controller output equals that error, bounded to the limits.
- R2: On each strobe the output becomes `floor((-A1*e_prev + B0*err + B1*err_prev) / 2^FRAC)`, bounded to the limits. The coefficients are signed with FRAC fraction bits. `e_prev` and `err_prev` are the output and error from the previous strobe.
- R3: An output above `e_max` becomes `e_max`, and an output below `e_min` becomes `e_min`. The bounded value, not the raw one, is stored as `e_prev`.
- R4: The on-time is `min(t_max, t_min + floor((e - e_min) * scale / 2^SF))`. Here `scale` is an unsigned value with SF fraction bits, precomputed as `(t_max - t_min)/(e_max - e_min)`. The on-time always stays within `[t_min, t_max]`.
- R5: The 2-bit mode is 1 (side A switching) when `e > deadband` and 2 (side B switching) when `e < -deadband`. Otherwise it is 3 (both sides idle). Code 0 never appears.
- R6: `valid` is high for exactly the one cycle after a strobe, and the outputs change only then. With no strobe, the state and outputs hold.
- R7: While reset is low, and after it is released, the stored output and error are zero, the mode is 3 and `valid` is low. The next strobe starts from zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample strobe, one cycle per loop update |
| target | input | IW | Commanded current, signed |
| meas | input | IW | Measured current, signed |
| coef_a1 | input | CW | Feedback coefficient A1, signed, FRAC fraction bits |
| coef_b0 | input | CW | Error coefficient B0, signed, FRAC fraction bits |
| coef_b1 | input | CW | Delayed error coefficient B1, signed, FRAC fraction bits |
| e_min | input | EW | Lower output limit, signed |
| e_max | input | EW | Upper output limit, signed |
| deadband | input | EW | Idle band half-width, non-negative |
| scale | input | SW | Mapping slope, unsigned, SF fraction bits |
| t_min | input | TW | Minimum on-time count |
| t_max | input | TW | Maximum on-time count |
| on_time | output | TW | High-side on-time count |
| mode | output | 2 | Drive mode: 1 side A, 2 side B, 3 idle |
| valid | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The range assertions assume the configuration is coherent and changes only between strobes. That means `e_min <= 0 <= e_max`, `t_min <= t_max`, and a non-negative deadband. They also assume the recursion's intermediate sum fits its accumulator, which the bench keeps true with coefficients of a few units and errors within ±2047. The stimulus programs every limit pair in order and writes configuration only while no strobe is pending. Each error sweep stays inside the input width, so every assertion runs against a configuration that honours those assumptions.

// File: rtl/tec_pi_pkg.sv
// Package: shared drive-mode encoding for the current regulator.
// Assumes the 2-bit code is decoded by a downstream PWM generator.
package tec_pi_pkg;
    typedef enum logic [1:0] {
        MODE_SIDE_A = 2'd1,
        MODE_SIDE_B = 2'd2,
        MODE_IDLE   = 2'd3
    } drive_mode_e;
endpackage

// File: rtl/tec_pi_core.sv
// PI recursion with bounded state.
// On each tick it computes the new output from the stored output and error,
// clamps it and stores the clamped value.
// Assumes e_min <= 0 <= e_max and that the accumulator is wide enough for the coefficients used.
module tec_pi_core #(
    parameter int IW   = 12,
    parameter int EW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic signed [IW:0]   err_now,
    input  logic signed [CW-1:0] coef_a1,
    input  logic signed [CW-1:0] coef_b0,
    input  logic signed [CW-1:0] coef_b1,
    input  logic signed [EW-1:0] e_min,
    input  logic signed [EW-1:0] e_max,
    output logic signed [EW-1:0] e_q
);
    localparam int AW = EW + CW + 3;

    logic signed [IW:0]   errp_q;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] acc_sh;
    logic signed [EW-1:0] e_next;

    // Purpose: form the raw recursion sum and scale it down by the fraction bits.
    always_comb begin
        acc = AW'(coef_b0) * AW'(err_now)
            + AW'(coef_b1) * AW'(errp_q)
            - AW'(coef_a1) * AW'(e_q);
        acc_sh = acc >>> FRAC;
    end

    // Purpose: bound the scaled sum to the programmed limits.
    always_comb begin
        if (acc_sh > AW'(e_max))      e_next = e_max;
        else if (acc_sh < AW'(e_min)) e_next = e_min;
        else                          e_next = EW'(acc_sh);
    end

    // Purpose: hold the bounded output and the error as history, updated only on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q    <= '0;
            errp_q <= '0;
        end else if (tick) begin
            e_q    <= e_next;
            errp_q <= err_now;
        end
    end

    AST_E_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (e_q >= e_min && e_q <= e_max)); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(e_q)); // R6
endmodule

// File: rtl/tec_ontime_map.sv
// Linear map from the bounded output to a high-side on-time count.
// One multiply by a precomputed slope replaces the division.
// Assumes e lies in [e_min, e_max] and t_min <= t_max.
module tec_ontime_map #(
    parameter int EW = 16,
    parameter int SW = 16,
    parameter int SF = 8,
    parameter int TW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [EW-1:0] e_val,
    input  logic signed [EW-1:0] e_min,
    input  logic        [SW-1:0] scale,
    input  logic        [TW-1:0] t_min,
    input  logic        [TW-1:0] t_max,
    output logic        [TW-1:0] on_time
);
    localparam int DW = EW + 1;
    localparam int MW = DW + SW + 1;

    logic signed [DW-1:0] offset;
    logic        [MW-1:0] prod;
    logic        [MW-1:0] total;

    // Purpose: offset from the lower limit, scaled and added to the minimum on-time.
    always_comb begin
        offset = DW'(e_val) - DW'(e_min);
        prod   = MW'($unsigned(offset)) * MW'(scale);
        total  = MW'(t_min) + (prod >> SF);
    end

    // Purpose: cap the result at the maximum on-time against rounding of the slope.
    always_comb begin
        if (total > MW'(t_max)) on_time = t_max;
        else                    on_time = TW'(total);
    end

    AST_ONTIME_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (on_time >= t_min && on_time <= t_max)); // R4
endmodule

// File: rtl/tec_mode_sel.sv
// Bridge mode selection from the sign of the bounded output, with a symmetric deadband.
// Assumes the deadband is non-negative.
module tec_mode_sel
    import tec_pi_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [EW-1:0] e_val,
    input  logic signed [EW-1:0] deadband,
    output drive_mode_e          mode
);
    logic signed [EW:0] lo_edge;

    // Purpose: choose side A above the band, side B below it, idle within it.
    always_comb begin
        lo_edge = -(EW+1)'(deadband);
        if ((EW+1)'(e_val) > (EW+1)'(deadband)) mode = MODE_SIDE_A;
        else if ((EW+1)'(e_val) < lo_edge)      mode = MODE_SIDE_B;
        else                                    mode = MODE_IDLE;
    end

    AST_MODE_A_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SIDE_A) |-> (e_val > 0)); // R5
    AST_MODE_B_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SIDE_B) |-> (e_val < 0)); // R5
endmodule

// File: rtl/tec_pi_reg.sv
// Top: inner current loop.
// Forms the error, runs the bounded PI recursion, maps the result to an on-time and picks the bridge mode.
// Results appear the cycle after tick, together with valid.
// Assumes configuration changes only between ticks.
module tec_pi_reg
    import tec_pi_pkg::*;
#(
    parameter int IW   = 12,
    parameter int EW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 8,
    parameter int SW   = 16,
    parameter int SF   = 8,
    parameter int TW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic signed [IW-1:0] target,
    input  logic signed [IW-1:0] meas,
    input  logic signed [CW-1:0] coef_a1,
    input  logic signed [CW-1:0] coef_b0,
    input  logic signed [CW-1:0] coef_b1,
    input  logic signed [EW-1:0] e_min,
    input  logic signed [EW-1:0] e_max,
    input  logic signed [EW-1:0] deadband,
    input  logic        [SW-1:0] scale,
    input  logic        [TW-1:0] t_min,
    input  logic        [TW-1:0] t_max,
    output logic        [TW-1:0] on_time,
    output logic        [1:0]    mode,
    output logic                 valid
);
    logic signed [IW:0]   err_now;
    logic signed [EW-1:0] e_q;
    drive_mode_e          mode_e;

    // Purpose: signed current error, one bit wider than the inputs.
    always_comb err_now = (IW+1)'(target) - (IW+1)'(meas);

    // Purpose: mark the cycle in which fresh results are presented.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= tick;
    end

    tec_pi_core #(.IW(IW), .EW(EW), .CW(CW), .FRAC(FRAC)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .err_now(err_now),
        .coef_a1(coef_a1), .coef_b0(coef_b0), .coef_b1(coef_b1),
        .e_min(e_min), .e_max(e_max), .e_q(e_q)
    );

    tec_ontime_map #(.EW(EW), .SW(SW), .SF(SF), .TW(TW)) u_map (
        .clk(clk), .rst_n(rst_n), .e_val(e_q), .e_min(e_min), .scale(scale),
        .t_min(t_min), .t_max(t_max), .on_time(on_time)
    );

    tec_mode_sel #(.EW(EW)) u_mode (
        .clk(clk), .rst_n(rst_n), .e_val(e_q), .deadband(deadband), .mode(mode_e)
    );

    assign mode = mode_e;

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (mode == MODE_IDLE && !valid)); // R7
    AST_NO_MODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd0); // R5
endmodule

// File: tb/tec_pi_reg_bench.sv
module tec_pi_reg_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic signed [11:0] target = '0, meas = '0;
    logic signed [15:0] coef_a1 = '0, coef_b0 = 16'sd256, coef_b1 = '0;
    logic signed [15:0] e_min = -16'sd1000, e_max = 16'sd1000, deadband = 16'sd20;
    logic [15:0] scale = 16'd256, t_min = 16'd0, t_max = 16'd2000;
    logic [15:0] on_time;
    logic [1:0]  mode;
    logic        valid;

    int checks = 0, errors = 0;
    longint m_e = 0, m_errp = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    tec_pi_reg u_tec_pi_reg (
        .clk(clk), .rst_n(rst_n), .tick(tick), .target(target), .meas(meas),
        .coef_a1(coef_a1), .coef_b0(coef_b0), .coef_b1(coef_b1),
        .e_min(e_min), .e_max(e_max), .deadband(deadband), .scale(scale),
        .t_min(t_min), .t_max(t_max), .on_time(on_time), .mode(mode), .valid(valid)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_on(input longint e);
        longint v;
        v = longint'(t_min) + (((e - longint'(e_min)) * longint'(scale)) >>> 8);
        if (v > longint'(t_max)) v = longint'(t_max);
        return v;
    endfunction

    function automatic longint exp_mode(input longint e);
        if (e > longint'(deadband)) return 1;
        if (e < -longint'(deadband)) return 2;
        return 3;
    endfunction

    // model update per R1, R2, R3
    task automatic model_step(input longint err);
        longint s;
        s = (-longint'(coef_a1) * m_e + longint'(coef_b0) * err + longint'(coef_b1) * m_errp) >>> 8;
        if (s > longint'(e_max)) s = longint'(e_max);
        if (s < longint'(e_min)) s = longint'(e_min);
        m_e = s;
        m_errp = err;
    endtask

    task automatic do_tick(input int tg, input int ms, input string req);
        @(negedge clk);
        target = 12'(tg);
        meas = 12'(ms);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_step(longint'(tg) - longint'(ms));
        chk({req, " valid"}, longint'(valid), 1);
        chk({req, " on_time"}, longint'(on_time), exp_on(m_e));
        chk({req, " mode"}, longint'(mode), exp_mode(m_e));
    endtask

    initial begin
        int seed = 7;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 reset valid", longint'(valid), 0);
        chk("R7 reset mode", longint'(mode), 3);
        chk("R7 reset on_time", longint'(on_time), exp_on(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 after release mode", longint'(mode), 3);

        // R1, R4, R5: proportional sweep, identity mapping
        for (int k = -1100; k <= 1100; k += 3) do_tick(k / 2, -(k - k / 2), "R1 R4 R5 sweep");

        // R4: narrow window 100..600
        @(negedge clk);
        scale = 16'd64; t_min = 16'd100; t_max = 16'd600;
        for (int k = -1050; k <= 1050; k += 7) do_tick(k, 0, "R4 window");
        do_tick(2047, 0, "R4 top edge");
        do_tick(-2048, 0, "R4 bottom edge");

        // R5: deadband edges
        @(negedge clk);
        scale = 16'd256; t_min = 16'd0; t_max = 16'd2000;
        do_tick(20, 0, "R5 at +band");
        do_tick(21, 0, "R5 above band");
        do_tick(-20, 0, "R5 at -band");
        do_tick(-21, 0, "R5 below band");
        do_tick(0, 0, "R5 zero");

        // R2, R3: integrating PI with pseudo-random errors and windup
        @(negedge clk);
        coef_a1 = -16'sd256; coef_b0 = 16'sd64; coef_b1 = -16'sd32;
        for (int n = 0; n < 300; n++) begin
            seed = seed * 1103515245 + 12345;
            do_tick(((seed >>> 8) % 900), 0, "R2 PI random");
        end
        for (int n = 0; n < 60; n++) do_tick(1500, -500, "R3 windup high");
        chk("R3 pinned high", m_e, 1000);
        for (int n = 0; n < 10; n++) do_tick(-300, 0, "R3 recovery");
        for (int n = 0; n < 60; n++) do_tick(-1500, 500, "R3 windup low");

        // R6: no tick, outputs hold and valid low
        begin
            logic [15:0] ot;
            logic [1:0] md;
            ot = on_time; md = mode;
            @(negedge clk);
            chk("R6 valid single cycle", longint'(valid), 0);
            target = 12'sd1999; meas = -12'sd1999;
            repeat (10) @(negedge clk);
            chk("R6 hold on_time", longint'(on_time), longint'(ot));
            chk("R6 hold mode", longint'(mode), longint'(md));
            chk("R6 hold valid", longint'(valid), 0);
        end
        do_tick(100, 0, "R6 resume history");

        // R7: reset mid-run clears history
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 mid reset mode", longint'(mode), 3);
        chk("R7 mid reset on_time", longint'(on_time), exp_on(0));
        rst_n = 1'b1;
        m_e = 0; m_errp = 0;
        do_tick(80, 0, "R7 fresh history");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule